// File: doc/BRIEF.md
# Paged memory card address decoder

This block decodes addresses for a 32 KB memory card on an 8-bit processor bus. The card holds sixteen 2 KB sockets. Each socket pair forms a 4 KB block, so there are eight blocks. Strap-style configuration inputs control each block:

- its 4 KB slot in the 64 KB space;
- its page (A or B);
- whether it holds RAM or read-only memory.

A single-page strap joins all eight blocks into one 32 KB page, which is controlled by page A. The block turns the incoming memory strobes into at most one socket chip select, plus a write enable and an output enable.

A two-bit page register sits at a fixed I/O port and switches the pages on and off. A page that is strapped to be on at reset reads its control bit in the reverse sense. Writing a 1 turns that page off.

The card stays silent while the external RAM-disable input is asserted. It can drive RAM-disable out when a read-only block is hit, so that system RAM lying underneath is suppressed. It can also stretch decoded accesses by 0 to 2 wait states.

The wait generator is a three-state machine:

- **ST_IDLE** moves to **ST_WAIT** on a decoded access when the wait count is non-zero. It moves to **ST_HOLD** when the count is zero.
- **ST_WAIT** holds the wait output low for one clock per wait state, then moves to **ST_HOLD**.
- **ST_HOLD** returns to **ST_IDLE** once both memory strobes are low.

Top module: `memcard_decode`

## Requirements
- R1: After reset the page register holds 0. With no page strapped on at reset, no access asserts any chip select, and `wait_n` is 1.
- R2: A write on `io_wr` with `io_addr` equal to the page port (parameter `PAGE_PORT`, default 8'hFE) loads `io_data[0]` as the page A bit and `io_data[1]` as the page B bit. The new value takes effect from the next clock edge. A write to any other port leaves the register unchanged.
- R3: Page p is on when its register bit XOR `cfg_reset_on[p]` is 1. So a page strapped on at reset is on until a 1 is written to its bit.
- R4: Block b matches when `addr[15:12]` equals `cfg_base[4b+3:4b]` and its page is on. Its page is `cfg_page[b]` (0 = A, 1 = B), or page A when `cfg_single` is 1. Blocks need not be contiguous.
- R5: A decoded access asserts exactly one chip select: `cs[2b + addr[11]]`.
- R6: When both pages match the same address, page A wins. Within a page, the lowest-numbered matching block wins.
- R7: For a read-only block (`cfg_rom[b]` = 1), a write asserts neither `cs` nor `we`. A read asserts `cs` and `oe`.
- R8: A write to a RAM block asserts `cs` and `we`. A read asserts `cs` and `oe` without `we`.
- R9: While `ramdis_in` is 1, `cs`, `we`, `oe` and `ramdis_out` are all 0.
- R10: `ramdis_out` is 1 during any decoded access to a read-only block when `cfg_romdis_en` is 1, and 0 otherwise.
- R11: A decoded access holds `wait_n` low for N clocks, where N = `cfg_waits` (values above 2 act as 2). The low period starts one clock after the access is first seen. A new wait period starts only after both strobes have dropped.
- R12: An access that is not decoded never drives `wait_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 16 | Memory address |
| mem_rd | input | 1 | Memory read strobe, active high |
| mem_wr | input | 1 | Memory write strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| io_addr | input | 8 | I/O port address |
| io_data | input | 8 | I/O write data |
| ramdis_in | input | 1 | External RAM-disable, active high |
| cfg_base | input | 32 | 4-bit base slot for each of the 8 blocks |
| cfg_page | input | 8 | Page of each block (0 = A, 1 = B) |
| cfg_rom | input | 8 | 1 marks a block as read-only |
| cfg_single | input | 1 | 1 makes one 32 KB page, controlled by page A |
| cfg_reset_on | input | 2 | Strap for each page: on at reset, reversed control bit |
| cfg_romdis_en | input | 1 | Enables `ramdis_out` on read-only hits |
| cfg_waits | input | 2 | Wait states per decoded access |
| cs | output | 16 | Socket chip selects, one-hot or zero |
| we | output | 1 | Write enable to the selected socket |
| oe | output | 1 | Output enable to the selected socket |
| ramdis_out | output | 1 | RAM-disable driven on read-only hits |
| wait_n | output | 1 | Bus wait, active low |

## Verification
The hardest cases to reach are the overlap and reversed-sense cases. Both need page-register writes combined with reset straps, because the page register can only be reached through I/O writes.

- **Overlap:** the bench maps a page B block onto the same slot as a page A block, switches both pages on through the port, and checks that the page A socket alone is selected.
- **Reversed sense:** the bench sets the reset strap for page B and checks that the page responds with its bit still clear. It then writes a 1 to the bit and checks that the page has gone silent.
- **Wait states:** a strobe is held across several clocks while the bench counts the low `wait_n` cycles for each wait setting.

// File: rtl/memcard_pkg.sv
package memcard_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_HOLD = 2'd2
    } wait_state_t;

    localparam int PAGE_A = 0;
    localparam int PAGE_B = 1;
    localparam int NUM_PAGES = 2;

endpackage

// File: rtl/memcard_page_reg.sv
module memcard_page_reg
    import memcard_pkg::*;
#(
    parameter int IO_AW = 8,
    parameter int IO_DW = 8,
    parameter logic [IO_AW-1:0] PAGE_PORT = 8'hFE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_wr,
    input  logic [IO_AW-1:0]     io_addr,
    input  logic [IO_DW-1:0]     io_data,
    input  logic [NUM_PAGES-1:0] cfg_reset_on,
    output logic [NUM_PAGES-1:0] page_on
);

    logic [NUM_PAGES-1:0] ctrl_q;
    logic                 port_hit;

    assign port_hit = io_wr && (io_addr == PAGE_PORT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (port_hit) begin
            ctrl_q <= io_data[NUM_PAGES-1:0];
        end
    end

    // a page strapped on at reset reads its bit in the reverse sense
    genvar p;
    generate
        for (p = 0; p < NUM_PAGES; p++) begin : g_page
            assign page_on[p] = ctrl_q[p] ^ cfg_reset_on[p];
        end
    endgenerate

endmodule

// File: rtl/memcard_block_match.sv
module memcard_block_match
    import memcard_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BLK_AW     = 12,
    parameter int NUM_BLOCKS = 8,
    localparam int BASE_W    = ADDR_W - BLK_AW,
    localparam int NUM_SOCK  = NUM_BLOCKS * 2,
    localparam int IDX_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic [NUM_BLOCKS*BASE_W-1:0] cfg_base,
    input  logic [NUM_BLOCKS-1:0]        cfg_page,
    input  logic [NUM_BLOCKS-1:0]        cfg_rom,
    input  logic                         cfg_single,
    input  logic [NUM_PAGES-1:0]         page_on,
    output logic                         hit,
    output logic                         rom_hit,
    output logic [NUM_SOCK-1:0]          sock_sel
);

    logic [NUM_BLOCKS-1:0] match_a;
    logic [NUM_BLOCKS-1:0] match_b;
    logic [BASE_W-1:0]     slot;

    assign slot = addr[ADDR_W-1:BLK_AW];

    genvar b;
    generate
        for (b = 0; b < NUM_BLOCKS; b++) begin : g_blk
            logic base_eq;
            logic in_b;
            assign base_eq    = (cfg_base[b*BASE_W +: BASE_W] == slot);
            assign in_b       = cfg_page[b] && !cfg_single;
            assign match_a[b] = base_eq && !in_b && page_on[PAGE_A];
            assign match_b[b] = base_eq &&  in_b && page_on[PAGE_B];
        end
    endgenerate

    logic             any_a;
    logic             any_b;
    logic [IDX_W-1:0] idx_a;
    logic [IDX_W-1:0] idx_b;
    logic [IDX_W-1:0] idx_sel;

    // lowest matching block in each page; page A takes precedence
    always_comb begin
        idx_a = '0;
        idx_b = '0;
        for (int i = NUM_BLOCKS - 1; i >= 0; i--) begin
            if (match_a[i]) idx_a = IDX_W'(i);
            if (match_b[i]) idx_b = IDX_W'(i);
        end
    end

    assign any_a   = |match_a;
    assign any_b   = |match_b;
    assign hit     = any_a || any_b;
    assign idx_sel = any_a ? idx_a : idx_b;
    assign rom_hit = hit && cfg_rom[idx_sel];

    always_comb begin
        sock_sel = '0;
        if (hit) begin
            sock_sel[{idx_sel, addr[BLK_AW-1]}] = 1'b1;
        end
    end

endmodule

// File: rtl/memcard_wait_fsm.sv
module memcard_wait_fsm
    import memcard_pkg::*;
#(
    parameter int MAX_WAITS = 2,
    parameter int WCFG_W    = 2,
    localparam int CNT_W    = $clog2(MAX_WAITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              decoded,
    input  logic [WCFG_W-1:0] cfg_waits,
    output logic              wait_n
);

    wait_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] waits_eff;

    assign waits_eff = (int'(cfg_waits) > MAX_WAITS) ? CNT_W'(MAX_WAITS)
                                                     : CNT_W'(cfg_waits);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (decoded) begin
                    if (waits_eff != '0) begin
                        state_d = ST_WAIT;
                        cnt_d   = waits_eff - 1'b1;
                    end else begin
                        state_d = ST_HOLD;
                    end
                end
            end
            ST_WAIT: begin
                if (cnt_q == '0) begin
                    state_d = ST_HOLD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_HOLD: begin
                if (!strobe) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_WAIT: wait_n = 1'b0;
            default: wait_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/memcard_decode.sv
module memcard_decode
    import memcard_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BLK_AW     = 12,
    parameter int NUM_BLOCKS = 8,
    parameter int IO_AW      = 8,
    parameter int IO_DW      = 8,
    parameter int MAX_WAITS  = 2,
    parameter int WCFG_W     = 2,
    parameter logic [IO_AW-1:0] PAGE_PORT = 8'hFE,
    localparam int BASE_W    = ADDR_W - BLK_AW,
    localparam int NUM_SOCK  = NUM_BLOCKS * 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         mem_rd,
    input  logic                         mem_wr,
    input  logic                         io_wr,
    input  logic [IO_AW-1:0]             io_addr,
    input  logic [IO_DW-1:0]             io_data,
    input  logic                         ramdis_in,
    input  logic [NUM_BLOCKS*BASE_W-1:0] cfg_base,
    input  logic [NUM_BLOCKS-1:0]        cfg_page,
    input  logic [NUM_BLOCKS-1:0]        cfg_rom,
    input  logic                         cfg_single,
    input  logic [NUM_PAGES-1:0]         cfg_reset_on,
    input  logic                         cfg_romdis_en,
    input  logic [WCFG_W-1:0]            cfg_waits,
    output logic [NUM_SOCK-1:0]          cs,
    output logic                         we,
    output logic                         oe,
    output logic                         ramdis_out,
    output logic                         wait_n
);

    logic [NUM_PAGES-1:0] page_on;
    logic                 hit;
    logic                 rom_hit;
    logic [NUM_SOCK-1:0]  sock_sel;
    logic                 strobe;
    logic                 access;
    logic                 rom_write;

    memcard_page_reg #(
        .IO_AW     (IO_AW),
        .IO_DW     (IO_DW),
        .PAGE_PORT (PAGE_PORT)
    ) page_reg_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .io_wr        (io_wr),
        .io_addr      (io_addr),
        .io_data      (io_data),
        .cfg_reset_on (cfg_reset_on),
        .page_on      (page_on)
    );

    memcard_block_match #(
        .ADDR_W     (ADDR_W),
        .BLK_AW     (BLK_AW),
        .NUM_BLOCKS (NUM_BLOCKS)
    ) match_i (
        .addr       (addr),
        .cfg_base   (cfg_base),
        .cfg_page   (cfg_page),
        .cfg_rom    (cfg_rom),
        .cfg_single (cfg_single),
        .page_on    (page_on),
        .hit        (hit),
        .rom_hit    (rom_hit),
        .sock_sel   (sock_sel)
    );

    assign strobe    = mem_rd || mem_wr;
    assign access    = strobe && hit && !ramdis_in;
    assign rom_write = mem_wr && rom_hit;

    assign cs         = (access && !rom_write) ? sock_sel : '0;
    assign we         = access && mem_wr && !rom_hit;
    assign oe         = access && mem_rd;
    assign ramdis_out = access && rom_hit && cfg_romdis_en;

    memcard_wait_fsm #(
        .MAX_WAITS (MAX_WAITS),
        .WCFG_W    (WCFG_W)
    ) wait_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (strobe),
        .decoded   (access),
        .cfg_waits (cfg_waits),
        .wait_n    (wait_n)
    );

endmodule

// File: rtl/memcard_decode_chk.sv
module memcard_decode_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        ramdis_in,
    input logic [1:0]  cfg_waits,
    input logic [15:0] cs,
    input logic        we,
    input logic        oe,
    input logic        ramdis_out,
    input logic        wait_n
);

    // R5
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs));

    // R9
    ramdis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramdis_in |-> (cs == '0 && !we && !oe && !ramdis_out));

    // R7
    rom_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramdis_out |-> !we);

    // R8
    we_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (mem_wr && $countones(cs) == 1));

    // R11
    no_wait_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_waits) == 2'd0 && $past(wait_n)) |-> wait_n);

    // R12
    wait_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wait_n) |-> ($past(mem_rd || mem_wr) && !$past(ramdis_in)));

endmodule

bind memcard_decode memcard_decode_chk chk_i (.*);

// File: tb/memcard_decode_tb_top.sv
`timescale 1ns/1ps
module memcard_decode_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        mem_rd = 1'b0;
    logic        mem_wr = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_addr = '0;
    logic [7:0]  io_data = '0;
    logic        ramdis_in = 1'b0;
    logic [31:0] cfg_base;
    logic [7:0]  cfg_page;
    logic [7:0]  cfg_rom;
    logic        cfg_single = 1'b0;
    logic [1:0]  cfg_reset_on = 2'b00;
    logic        cfg_romdis_en = 1'b1;
    logic [1:0]  cfg_waits = 2'd0;
    logic [15:0] cs;
    logic        we, oe, ramdis_out, wait_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    memcard_decode dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data), .ramdis_in(ramdis_in),
        .cfg_base(cfg_base), .cfg_page(cfg_page), .cfg_rom(cfg_rom),
        .cfg_single(cfg_single), .cfg_reset_on(cfg_reset_on),
        .cfg_romdis_en(cfg_romdis_en), .cfg_waits(cfg_waits),
        .cs(cs), .we(we), .oe(oe), .ramdis_out(ramdis_out), .wait_n(wait_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        @(negedge clk);
        mem_rd = 0; mem_wr = 0; ramdis_in = 0;
        @(negedge clk);
    endtask

    task automatic page_write(input logic [7:0] port, input logic [7:0] val);
        @(negedge clk);
        io_wr = 1; io_addr = port; io_data = val;
        @(negedge clk);
        io_wr = 0;
    endtask

    // combinational access probe: returns {we, oe, ramdis_out, cs}
    task automatic probe(input logic [15:0] a, input bit wr, output logic [18:0] res);
        @(negedge clk);
        addr = a; mem_rd = !wr; mem_wr = wr;
        #1;
        res = {we, oe, ramdis_out, cs};
        @(negedge clk);
        mem_rd = 0; mem_wr = 0;
        @(negedge clk);
    endtask

    function automatic logic [15:0] onehot(input int n);
        return 16'(1) << n;
    endfunction

    task automatic t_reset();
        logic [18:0] r;
        check("R1 wait_n after reset", 32'(wait_n), 1);
        probe(16'h0123, 0, r);
        check("R1 no cs with pages off", 32'(r), 0);
    endtask

    task automatic t_page_a_sockets();
        logic [18:0] r;
        page_write(8'hFE, 8'h01);
        probe(16'h0123, 0, r);
        check("R5 lower socket block0", 32'(r), 32'({3'b010, onehot(0)}));
        probe(16'h0923, 0, r);
        check("R5 upper socket block0", 32'(r), 32'({3'b010, onehot(1)}));
        probe(16'h8800, 0, r);
        check("R4 noncontiguous block1", 32'(r), 32'({3'b010, onehot(3)}));
        probe(16'hC000, 0, r);
        check("R4 page B block off", 32'(r), 0);
    endtask

    task automatic t_port_filter();
        logic [18:0] r;
        page_write(8'hFD, 8'h00);
        probe(16'h0123, 0, r);
        check("R2 other port ignored", 32'(r[15:0]), 32'(onehot(0)));
        page_write(8'hFE, 8'h03);
        probe(16'hC000, 0, r);
        check("R2 page B enabled via port", 32'(r[15:0]), 32'(onehot(8)));
    endtask

    task automatic t_overlap();
        logic [18:0] r;
        cfg_base[23:20] = 4'h0;
        probe(16'h0400, 0, r);
        check("R6 page A wins overlap", 32'(r[15:0]), 32'(onehot(0)));
        cfg_base[23:20] = 4'hC;
        probe(16'hC800, 0, r);
        check("R6 lowest block wins", 32'(r[15:0]), 32'(onehot(9)));
    endtask

    task automatic t_rom_ram();
        logic [18:0] r;
        probe(16'h3100, 0, r);
        check("R7 rom read", 32'(r), 32'({3'b011, onehot(4)}));
        check("R10 ramdis_out on rom hit", 32'(r[16]), 1);
        probe(16'h3100, 1, r);
        check("R7 rom write ignored", 32'({r[18], r[15:0]}), 0);
        cfg_romdis_en = 0;
        probe(16'h3100, 0, r);
        check("R10 ramdis_out disabled", 32'(r[16]), 0);
        cfg_romdis_en = 1;
        probe(16'h0200, 1, r);
        check("R8 ram write", 32'(r), 32'({3'b100, onehot(0)}));
        probe(16'h0200, 0, r);
        check("R10 no ramdis on ram", 32'(r[16]), 0);
    endtask

    task automatic t_ramdis_in();
        @(negedge clk);
        ramdis_in = 1; addr = 16'h3000; mem_rd = 1;
        #1;
        check("R9 ramdis_in silences card", 32'({we, oe, ramdis_out, cs}), 0);
        idle_bus();
    endtask

    task automatic t_reset_on();
        logic [18:0] r;
        page_write(8'hFE, 8'h01);
        cfg_reset_on = 2'b10;
        @(negedge clk);
        probe(16'hC000, 0, r);
        check("R3 strapped page on with bit clear", 32'(r[15:0]), 32'(onehot(8)));
        page_write(8'hFE, 8'h03);
        probe(16'hC000, 0, r);
        check("R3 writing 1 turns strapped page off", 32'(r[15:0]), 0);
        cfg_reset_on = 2'b00;
    endtask

    task automatic t_single();
        logic [18:0] r;
        page_write(8'hFE, 8'h01);
        cfg_single = 1;
        probe(16'hC000, 0, r);
        check("R4 single page joins page B blocks", 32'(r[15:0]), 32'(onehot(8)));
        cfg_single = 0;
    endtask

    task automatic t_waits(input logic [1:0] w, input logic [15:0] a, input int exp, input string req);
        int lows = 0;
        cfg_waits = w;
        @(negedge clk);
        addr = a; mem_rd = 1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!wait_n) lows++;
        end
        mem_rd = 0;
        @(negedge clk);
        @(negedge clk);
        check(req, 32'(lows), 32'(exp));
        cfg_waits = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        cfg_base = {4'h7, 4'h6, 4'h0, 4'hC, 4'hE, 4'h3, 4'h8, 4'h0};
        cfg_base[23:20] = 4'hC;
        cfg_page = 8'b1111_0000;
        cfg_rom  = 8'b0000_0100;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_page_a_sockets();
        t_port_filter();
        t_overlap();
        t_rom_ram();
        t_ramdis_in();
        t_waits(2'd0, 16'h0100, 0, "R11 zero waits");
        t_waits(2'd1, 16'h0100, 1, "R11 one wait");
        t_waits(2'd2, 16'h0100, 2, "R11 two waits");
        t_waits(2'd3, 16'h0100, 2, "R11 waits saturate at two");
        t_waits(2'd2, 16'h5000, 0, "R12 miss gives no wait");
        t_reset_on();
        t_single();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule